// File: doc/BRIEF.md
# Low-Side Driver Gate Controller

This block sits between the control registers of a 16-channel low-side switch and the gate drivers of its output transistors. Every clock it combines each channel's on/off command with a shared PWM input. For that it uses a per-channel PWM select and a per-channel gating mode that chooses AND or OR. It then removes the drive from channels that the protection logic has switched off. The result is one registered gate-enable bit per channel.

Three digital fault sources are handled. A supply over-voltage comparator flag is qualified by a clock-cycle timer and then shuts every channel. A per-channel over-temperature flag shuts only its own channel. A per-channel drain-voltage-high flag shuts a conducting channel after a fixed filter time, unless that channel is configured to rely on thermal protection alone. The recovery after an over-voltage or thermal event follows a programmable policy: the channel either resumes or stays latched off. A latched channel is released when the host writes its on/off bit to 0. The external reset pin and the two supply under-voltage flags force all gates off and discard all latched state.

Top module: `lsd_gate_ctrl`

## Requirements
- R1: The gate of a channel whose PWM-select bit is 0 equals its on bit. With PWM-select 1, the gate equals on AND pwm_in when its mode bit is 0, and on OR pwm_in when its mode bit is 1. Each gate is registered and shows its inputs one clock after they are sampled.
- R2: An ov_flag held high for fewer than OV_QUAL_CYC consecutive clocks leaves the gates unchanged. On the OV_QUAL_CYC-th consecutive high sample, all gates go to 0 and stay 0 while the flag remains high.
- R3: With ov_resume = 1, the gates return to their commanded values on the first clock that samples ov_flag low after a qualified over-voltage. With ov_resume = 0, every channel stays off after the flag clears.
- R4: A high ot_flag bit forces only that channel's gate to 0 on the next clock. When the bit clears, therm_retry = 1 restores the channel on the next clock, and therm_retry = 0 keeps it off.
- R5: A channel with therm_only = 0 whose gate is 1 while its vds_hi bit is high for SHORT_FILT_CYC consecutive clocks goes to 0 on that clock and stays off after vds_hi clears. With therm_only = 1, vds_hi has no effect on the gate.
- R6: The rst input, rst_pin_n = 0, uv_supply = 1 or uv_logic = 1 forces every gate to 0 on the next clock and clears all latched faults and timers. The gates follow their commands again on the clock after the condition ends.
- R7: A latched-off channel remains off until a clock samples its on bit at 0. After that, setting the bit back to 1 turns the channel on again on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pin_n | input | 1 | External active-low reset request, sampled synchronously |
| uv_supply | input | 1 | Load-supply under-voltage flag |
| uv_logic | input | 1 | Logic-supply under-voltage flag |
| pwm_in | input | 1 | Shared PWM input |
| ov_flag | input | 1 | Load-supply over-voltage comparator flag |
| ot_flag | input | NCH | Per-channel over-temperature flag |
| vds_hi | input | NCH | Per-channel drain-source voltage above short threshold |
| on_bits | input | NCH | Per-channel on/off command |
| pwm_sel | input | NCH | Per-channel PWM select |
| or_mode | input | NCH | Per-channel gating mode, 0 = AND, 1 = OR |
| therm_only | input | NCH | Per-channel: 1 disables the fast short shutdown |
| ov_resume | input | 1 | Over-voltage recovery policy, 1 = resume |
| therm_retry | input | 1 | Thermal recovery policy, 1 = retry |
| gate | output | NCH | Registered gate enables |

## Verification
Every gate result is due exactly one rising edge after the inputs that cause it are sampled. The bench therefore changes inputs on a falling edge, lets one rising edge pass and reads the gates on the next falling edge. The over-voltage test steps the flag one clock at a time. It reads the gates after OV_QUAL_CYC − 1 edges, where they must still be on, and after OV_QUAL_CYC edges, where they must be off. The short-filter test does the same around SHORT_FILT_CYC. Recovery and re-arm checks each fall one edge after the flag or on bit changes.

// File: rtl/lsdg_pkg.sv
package lsdg_pkg;

    // Per-channel configuration as seen by one channel slice
    typedef struct packed {
        logic on;          // commanded state
        logic pwm_sel;     // PWM pin participates
        logic or_mode;     // 1: OR with PWM, 0: AND with PWM
        logic therm_only;  // 1: no fast short shutdown
    } chan_cfg_t;

    // Fault inputs of one channel slice
    typedef struct packed {
        logic ot;          // over-temperature comparator
        logic vds_hi;      // drain voltage above short threshold
    } chan_flt_t;

    // Global protection state broadcast to all slices
    typedef struct packed {
        logic ov_off;      // qualified over-voltage, gates off
        logic ov_latch;    // latch channels off (policy: stay off)
        logic therm_retry; // thermal recovery policy
        logic hard_off;    // reset pin or supply under-voltage
    } glob_ctl_t;

    // Width for a counter that must hold 0..n
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Command mixing of on bit and PWM pin
    function automatic logic mix_request(input chan_cfg_t c, input logic pwm);
        logic r;
        if (!c.pwm_sel)
            r = c.on;
        else if (c.or_mode)
            r = c.on | pwm;
        else
            r = c.on & pwm;
        return r;
    endfunction

endpackage

// File: rtl/lsdg_ov_qual.sv
module lsdg_ov_qual
    import lsdg_pkg::*;
#(
    parameter int unsigned QUAL_CYC = 6250
) (
    input  logic clk,
    input  logic rst,
    input  logic hard_off,
    input  logic ov_flag,
    output logic ov_active_nxt,
    output logic ov_active
);
    localparam int unsigned CW = cnt_width(QUAL_CYC);
    localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYC);

    logic [CW-1:0] cnt_q, cnt_n;

    always_comb begin
        if (!ov_flag)
            cnt_n = '0;
        else if (cnt_q >= LIMIT)
            cnt_n = cnt_q;
        else
            cnt_n = cnt_q + 1'b1;
        ov_active_nxt = ov_flag && (cnt_n >= LIMIT) && !hard_off;
    end

    always_ff @(posedge clk) begin
        if (rst || hard_off) begin
            cnt_q     <= '0;
            ov_active <= 1'b0;
        end else begin
            cnt_q     <= cnt_n;
            ov_active <= ov_active_nxt;
        end
    end

    AST_OV_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT); // R2
    AST_OV_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        !ov_flag |=> !ov_active); // R2

endmodule

// File: rtl/lsdg_chan.sv
module lsdg_chan
    import lsdg_pkg::*;
#(
    parameter int unsigned FILT_CYC = 34375
) (
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg,
    input  chan_flt_t flt,
    input  glob_ctl_t gctl,
    input  logic      pwm_in,
    output logic      gate
);
    localparam int unsigned SW = cnt_width(FILT_CYC);
    localparam logic [SW-1:0] FILT = SW'(FILT_CYC);

    logic [SW-1:0] scnt_q, scnt_n;
    logic          lock_q, lock_n;
    logic          gate_q, gate_n;
    logic          req, short_arm, trip, lock_set;

    always_comb begin
        req       = mix_request(cfg, pwm_in);
        short_arm = gate_q && flt.vds_hi && !cfg.therm_only;
        if (!short_arm)
            scnt_n = '0;
        else if (scnt_q >= FILT)
            scnt_n = scnt_q;
        else
            scnt_n = scnt_q + 1'b1;
        trip     = short_arm && (scnt_n >= FILT);
        lock_set = trip || gctl.ov_latch || (flt.ot && !gctl.therm_retry);
        lock_n   = (lock_q || lock_set) && cfg.on;
        gate_n   = req && !flt.ot && !gctl.ov_off && !lock_q && !trip;
    end

    always_ff @(posedge clk) begin
        if (rst || gctl.hard_off) begin
            scnt_q <= '0;
            lock_q <= 1'b0;
            gate_q <= 1'b0;
        end else begin
            scnt_q <= scnt_n;
            lock_q <= lock_n;
            gate_q <= gate_n;
        end
    end

    assign gate = gate_q;

    AST_NO_REQ_NO_GATE: assert property (@(posedge clk) disable iff (rst)
        !req |=> !gate_q); // R1
    AST_OT_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
        flt.ot |=> !gate_q); // R4
    AST_SHORT_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        scnt_q <= FILT); // R5
    AST_LOCK_KEEPS_OFF: assert property (@(posedge clk) disable iff (rst)
        lock_q |-> !gate_q); // R7

endmodule

// File: rtl/lsd_gate_ctrl.sv
module lsd_gate_ctrl
    import lsdg_pkg::*;
#(
    parameter int unsigned NCH            = 16,
    parameter int unsigned OV_QUAL_CYC    = 6250,
    parameter int unsigned SHORT_FILT_CYC = 34375
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rst_pin_n,
    input  logic           uv_supply,
    input  logic           uv_logic,
    input  logic           pwm_in,
    input  logic           ov_flag,
    input  logic [NCH-1:0] ot_flag,
    input  logic [NCH-1:0] vds_hi,
    input  logic [NCH-1:0] on_bits,
    input  logic [NCH-1:0] pwm_sel,
    input  logic [NCH-1:0] or_mode,
    input  logic [NCH-1:0] therm_only,
    input  logic           ov_resume,
    input  logic           therm_retry,
    output logic [NCH-1:0] gate
);
    logic      hard_off;
    logic      ov_active_nxt, ov_active;
    glob_ctl_t gctl;

    assign hard_off = !rst_pin_n || uv_supply || uv_logic;

    lsdg_ov_qual #(.QUAL_CYC(OV_QUAL_CYC)) u_ov (
        .clk          (clk),
        .rst          (rst),
        .hard_off     (hard_off),
        .ov_flag      (ov_flag),
        .ov_active_nxt(ov_active_nxt),
        .ov_active    (ov_active)
    );

    always_comb begin
        gctl.ov_off      = ov_active_nxt;
        gctl.ov_latch    = ov_active_nxt && !ov_resume;
        gctl.therm_retry = therm_retry;
        gctl.hard_off    = hard_off;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chan_cfg_t cfg;
        chan_flt_t flt;
        always_comb begin
            cfg.on         = on_bits[i];
            cfg.pwm_sel    = pwm_sel[i];
            cfg.or_mode    = or_mode[i];
            cfg.therm_only = therm_only[i];
            flt.ot         = ot_flag[i];
            flt.vds_hi     = vds_hi[i];
        end
        lsdg_chan #(.FILT_CYC(SHORT_FILT_CYC)) u_ch (
            .clk   (clk),
            .rst   (rst),
            .cfg   (cfg),
            .flt   (flt),
            .gctl  (gctl),
            .pwm_in(pwm_in),
            .gate  (gate[i])
        );
    end

    AST_OV_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        ov_active |-> (gate == '0)); // R2
    AST_HARD_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        hard_off |=> (gate == '0)); // R6

endmodule

// File: tb/tb_lsd_gate_ctrl.sv
module tb_lsd_gate_ctrl;
    localparam int NCH = 16;
    localparam int OVQ = 8;
    localparam int SFC = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_pin_n = 1'b1, uv_supply = 1'b0, uv_logic = 1'b0;
    logic pwm_in = 1'b0, ov_flag = 1'b0;
    logic [NCH-1:0] ot_flag = '0, vds_hi = '0, on_bits = '0;
    logic [NCH-1:0] pwm_sel = '0, or_mode = '0, therm_only = '0;
    logic ov_resume = 1'b1, therm_retry = 1'b1;
    logic [NCH-1:0] gate;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lsd_gate_ctrl #(.NCH(NCH), .OV_QUAL_CYC(OVQ), .SHORT_FILT_CYC(SFC)) dut (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .uv_supply(uv_supply),
        .uv_logic(uv_logic), .pwm_in(pwm_in), .ov_flag(ov_flag),
        .ot_flag(ot_flag), .vds_hi(vds_hi), .on_bits(on_bits),
        .pwm_sel(pwm_sel), .or_mode(or_mode), .therm_only(therm_only),
        .ov_resume(ov_resume), .therm_retry(therm_retry), .gate(gate)
    );

    // on, pwm_sel, or_mode, pwm_in, expected gate
    localparam logic [64:0] VTAB [0:5] = '{
        {16'h00FF, 16'h0F0F, 16'h3333, 1'b0, 16'h00F3},
        {16'h00FF, 16'h0F0F, 16'h3333, 1'b1, 16'h03FF},
        {16'hA5A5, 16'hFFFF, 16'h0000, 1'b1, 16'hA5A5},
        {16'hA5A5, 16'hFFFF, 16'h0000, 1'b0, 16'h0000},
        {16'h0000, 16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF},
        {16'h1234, 16'h0000, 16'hFFFF, 1'b1, 16'h1234}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [NCH-1:0] exp);
        nvec++;
        if (gate !== exp) begin
            nfail++;
            $display("FAIL %s: gate=%h expected=%h", tag, gate, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        on_bits = 16'hFFFF;
        step(2);
        check("R6 reset", 16'h0000);
        rst = 1'b0;
        step(1);
        check("R6 after reset", 16'hFFFF);

        // R1: mixing table
        for (int k = 0; k < 6; k++) begin
            on_bits = VTAB[k][64:49];
            pwm_sel = VTAB[k][48:33];
            or_mode = VTAB[k][32:17];
            pwm_in  = VTAB[k][16];
            step(1);
            check("R1 mix", VTAB[k][15:0]);
        end
        on_bits = 16'hFFFF; pwm_sel = '0; or_mode = '0; pwm_in = 1'b0;
        step(1);
        check("R1 plain on", 16'hFFFF);

        // R2/R3: qualification and resume
        ov_resume = 1'b1;
        ov_flag = 1'b1;
        for (int k = 1; k < OVQ; k++) begin
            step(1);
            check("R2 unqualified", 16'hFFFF);
        end
        step(1);
        check("R2 qualified", 16'h0000);
        step(3);
        check("R2 held", 16'h0000);
        ov_flag = 1'b0;
        step(1);
        check("R3 resume", 16'hFFFF);

        // R3/R7: stay-off policy, then re-arm
        ov_resume = 1'b0;
        ov_flag = 1'b1;
        step(OVQ);
        check("R2 qualified again", 16'h0000);
        ov_flag = 1'b0;
        step(1);
        check("R3 stay off", 16'h0000);
        step(4);
        check("R3 still off", 16'h0000);
        on_bits = 16'h0000;
        step(1);
        on_bits = 16'hFFFF;
        step(1);
        check("R7 rearm after ov", 16'hFFFF);
        ov_resume = 1'b1;

        // R4: thermal retry and latch
        therm_retry = 1'b1;
        ot_flag = 16'h0008;
        step(1);
        check("R4 ot off", 16'hFFF7);
        ot_flag = '0;
        step(1);
        check("R4 retry", 16'hFFFF);
        therm_retry = 1'b0;
        ot_flag = 16'h0020;
        step(1);
        check("R4 ot off latch", 16'hFFDF);
        ot_flag = '0;
        step(4);
        check("R4 latched", 16'hFFDF);
        on_bits = 16'hFFDF;
        step(1);
        check("R7 on low", 16'hFFDF);
        on_bits = 16'hFFFF;
        step(1);
        check("R7 rearm thermal", 16'hFFFF);

        // R5: short filter, thermal-only exemption
        therm_only = 16'h0200;
        vds_hi = 16'h0204;
        step(SFC - 1);
        check("R5 before filter", 16'hFFFF);
        step(1);
        check("R5 trip", 16'hFFFB);
        step(20);
        check("R5 therm_only unaffected", 16'hFFFB);
        vds_hi = '0;
        step(3);
        check("R5 latched", 16'hFFFB);
        on_bits = 16'hFFFB;
        step(1);
        on_bits = 16'hFFFF;
        step(1);
        check("R7 rearm short", 16'hFFFF);

        // R6: hard-off sources, clear latch
        rst_pin_n = 1'b0;
        step(1);
        check("R6 pin reset", 16'h0000);
        rst_pin_n = 1'b1;
        step(1);
        check("R6 pin release", 16'hFFFF);
        ot_flag = 16'h0001;
        step(1);
        ot_flag = '0;
        step(1);
        check("R4 latched ch0", 16'hFFFE);
        uv_logic = 1'b1;
        step(1);
        check("R6 uv_logic", 16'h0000);
        uv_logic = 1'b0;
        step(1);
        check("R6 latch cleared", 16'hFFFF);
        uv_supply = 1'b1;
        step(1);
        check("R6 uv_supply", 16'h0000);
        uv_supply = 1'b0;
        step(1);
        check("R6 uv release", 16'hFFFF);

        finish_run();
    end
endmodule